// File: doc/BRIEF.md
# Sub-Cycle Resolution PWM Duty Comparator

This block produces edge-aligned pulse-width-modulated outputs whose pulse width resolves to a quarter of an instruction cycle. Each instruction cycle is four system clocks long, the phases Q1 to Q4. A period timer counts instruction cycles, scaled by a 2-bit prescaler setting, and wraps after reaching the programmed period value. Every channel's output goes high at the first phase of each period and drops when its qualified duty match occurs.

Three channels each hold a 14-bit duty value. Software writes it one byte at a time into a pending copy. The pending copy moves into the working copy only when a new period starts, so a pulse already in progress is never disturbed. The upper twelve duty bits are compared with the period timer. With a 1:1 prescaler, the two lowest bits pick the phase within the matching instruction cycle on which the pulse ends. This is why a duty expressed in timer counts is programmed as four times that count.

Top module: `qpwm_top`

## Requirements
- R1: A duty value is 14 bits. A write with `wr_hi_i`=0 sets its bits 7:0 from `wr_data_i`. A write with `wr_hi_i`=1 sets bits 13:8 from `wr_data_i[5:0]`, and `wr_data_i[7:6]` is discarded. `rd_data_o` combinationally returns the pending value of channel `rd_sel_i`: bits 7:0 when `rd_hi_i`=0, and {2'b00, bits 13:8} when it is 1. Channel selects 0 to 2 are valid.
- R2: While `rst_n` is low, every output in `pwm_o` is 0 and every pending duty reads back as 0.
- R3: With `prescale_i`=00 (1:1), a channel holding duty D stays high for exactly min(D, 4*(P+1)) system clocks in each period, where P is `period_i`. The pulse ends at timer value D[13:2] on phase D[1:0], with 00=Q1 and 11=Q4.
- R4: With `prescale_i` at 01, 10 or 11 (1:4, 1:16, 1:64 instruction cycles per timer count, L=4, 16, 64), D[1:0] has no effect. The output stays high for min(D[13:2]*4*L, 4*L*(P+1)) clocks.
- R5: The phase advances on every clock. The timer advances only at the end of Q4, once every L instruction cycles, and wraps from P to 0. A period therefore lasts 4*L*(P+1) clocks, and the first period begins on the first clock after reset.
- R6: An output can only rise on the clock that follows the first Q1 of a period, which is timer 0 with the prescaler count at 0.
- R7: The working duty of a channel changes only at a period start, and then takes the pending value present at that moment. Writes made during a period take effect in the next one.
- R8: A working duty of 0 keeps the output low for the whole period.
- R9: A working duty whose bits 13:2 exceed P keeps the output high for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (one phase per cycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | 12 | Last timer value of a period |
| prescale_i | input | 2 | Timer prescale: 00=1:1, 01=1:4, 10=1:16, 11=1:64 |
| wr_en_i | input | 1 | Byte write strobe |
| wr_sel_i | input | 2 | Channel addressed by a write |
| wr_hi_i | input | 1 | Write targets the high byte |
| wr_data_i | input | 8 | Write data byte |
| rd_sel_i | input | 2 | Channel addressed by a read |
| rd_hi_i | input | 1 | Read the high byte |
| rd_data_o | output | 8 | Pending duty byte |
| pwm_o | output | 3 | Active-high PWM outputs, one per channel |

## Verification
The bench builds the block with its default parameters: three channels and a 12-bit timer. It keeps period values between 1 and 6, so a period lasts from 8 to a few hundred clocks, and every prescale setting, including 1:64, completes several periods within the run. Small periods make it easy to reach the boundary cases: a duty of zero, a duty ending on Q4 of the last timer count, and duties far above the period. They also allow several mid-period rewrites of the pending copy in every case.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;

  typedef enum logic [1:0] {
    PS_DIV1  = 2'b00,
    PS_DIV4  = 2'b01,
    PS_DIV16 = 2'b10,
    PS_DIV64 = 2'b11
  } prescale_e;

  localparam int PC_W = 6;

  // last value of the instruction-cycle counter before the timer steps
  function automatic logic [PC_W-1:0] presc_last(input logic [1:0] ps);
    case (prescale_e'(ps))
      PS_DIV1:  presc_last = 6'd0;
      PS_DIV4:  presc_last = 6'd3;
      PS_DIV16: presc_last = 6'd15;
      default:  presc_last = 6'd63;
    endcase
  endfunction

  // phase qualification of a duty match
  function automatic logic phase_hit(input logic fine_en, input logic [1:0] phase,
                                     input logic [1:0] sel, input logic first_q1);
    phase_hit = fine_en ? (phase == sel) : first_q1;
  endfunction

endpackage

// File: rtl/qpwm_timebase.sv
module qpwm_timebase
  import qpwm_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] period_i,
  input  logic [1:0]    prescale_i,
  output logic [1:0]    phase_o,
  output logic [TW-1:0] timer_o,
  output logic          first_q1_o,
  output logic          period_start_o
);

  logic [1:0]      ph_q;
  logic [PC_W-1:0] pc_q;
  logic [TW-1:0]   tm_q;
  logic            end_q4;
  logic            pc_done;

  assign end_q4  = (ph_q == 2'd3);
  assign pc_done = (pc_q >= presc_last(prescale_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 2'd0;
      pc_q <= '0;
      tm_q <= '0;
    end else begin
      ph_q <= ph_q + 2'd1;
      if (end_q4) begin
        if (pc_done) begin
          pc_q <= '0;
          tm_q <= (tm_q >= period_i) ? '0 : tm_q + TW'(1);
        end else begin
          pc_q <= pc_q + PC_W'(1);
        end
      end
    end
  end

  assign phase_o        = ph_q;
  assign timer_o        = tm_q;
  assign first_q1_o     = (ph_q == 2'd0) && (pc_q == '0);
  assign period_start_o = first_q1_o && (tm_q == '0);

endmodule

// File: rtl/qpwm_duty_bank.sv
module qpwm_duty_bank #(
  parameter int NCH = 3,
  parameter int DW  = 14,
  parameter int SW  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_i,
  input  logic [SW-1:0]           wr_sel_i,
  input  logic                    wr_hi_i,
  input  logic [7:0]              wr_data_i,
  input  logic [SW-1:0]           rd_sel_i,
  input  logic                    rd_hi_i,
  output logic [7:0]              rd_data_o,
  input  logic                    period_start_i,
  output logic [NCH-1:0][DW-1:0]  pend_o,
  output logic [NCH-1:0][DW-1:0]  work_o,
  output logic [NCH-1:0][DW-1:0]  eff_o
);

  localparam int HI_W = DW - 8;

  logic [NCH-1:0][DW-1:0] pend_q;
  logic [NCH-1:0][DW-1:0] work_q;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic hit;
    assign hit = wr_en_i && (wr_sel_i == SW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= '0;
      end else if (hit) begin
        if (wr_hi_i) pend_q[g][DW-1:8] <= wr_data_i[HI_W-1:0];
        else         pend_q[g][7:0]    <= wr_data_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              work_q[g] <= '0;
      else if (period_start_i) work_q[g] <= pend_q[g];
    end

    assign eff_o[g] = period_start_i ? pend_q[g] : work_q[g];
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < NCH; i++) begin
      if (rd_sel_i == SW'(i)) begin
        rd_data_o = rd_hi_i ? {{(8-HI_W){1'b0}}, pend_q[i][DW-1:8]} : pend_q[i][7:0];
      end
    end
  end

  assign pend_o = pend_q;
  assign work_o = work_q;

endmodule

// File: rtl/qpwm_channel.sv
module qpwm_channel
  import qpwm_pkg::*;
#(
  parameter int TW = 12,
  parameter int DW = TW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    phase_i,
  input  logic [TW-1:0] timer_i,
  input  logic          first_q1_i,
  input  logic          period_start_i,
  input  logic          fine_en_i,
  input  logic [DW-1:0] duty_i,
  output logic          match_o,
  output logic          pwm_o
);

  logic coarse_eq;
  logic pwm_q;

  assign coarse_eq = (duty_i[DW-1:2] == timer_i);
  assign match_o   = coarse_eq && phase_hit(fine_en_i, phase_i, duty_i[1:0], first_q1_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pwm_q <= 1'b0;
    else if (match_o)        pwm_q <= 1'b0;
    else if (period_start_i) pwm_q <= 1'b1;
  end

  assign pwm_o = pwm_q;

endmodule

// File: rtl/qpwm_top.sv
module qpwm_top
  import qpwm_pkg::*;
#(
  parameter int NCH = 3,
  parameter int TW  = 12,
  parameter int SW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  period_i,
  input  logic [1:0]     prescale_i,
  input  logic           wr_en_i,
  input  logic [SW-1:0]  wr_sel_i,
  input  logic           wr_hi_i,
  input  logic [7:0]     wr_data_i,
  input  logic [SW-1:0]  rd_sel_i,
  input  logic           rd_hi_i,
  output logic [7:0]     rd_data_o,
  output logic [NCH-1:0] pwm_o
);

  localparam int DW = TW + 2;

  logic [1:0]             phase_w;
  logic [TW-1:0]          timer_w;
  logic                   first_q1_w;
  logic                   period_start_w;
  logic                   fine_en_w;
  logic [NCH-1:0][DW-1:0] pend_w;
  logic [NCH-1:0][DW-1:0] work_w;
  logic [NCH-1:0][DW-1:0] eff_w;
  logic [NCH-1:0]         match_w;

  assign fine_en_w = (prescale_i == PS_DIV1);

  qpwm_timebase #(.TW(TW)) u_tb (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .prescale_i(prescale_i),
    .phase_o(phase_w), .timer_o(timer_w), .first_q1_o(first_q1_w),
    .period_start_o(period_start_w)
  );

  qpwm_duty_bank #(.NCH(NCH), .DW(DW), .SW(SW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_hi_i(wr_hi_i), .wr_data_i(wr_data_i),
    .rd_sel_i(rd_sel_i), .rd_hi_i(rd_hi_i), .rd_data_o(rd_data_o),
    .period_start_i(period_start_w),
    .pend_o(pend_w), .work_o(work_w), .eff_o(eff_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    qpwm_channel #(.TW(TW), .DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n), .phase_i(phase_w), .timer_i(timer_w),
      .first_q1_i(first_q1_w), .period_start_i(period_start_w),
      .fine_en_i(fine_en_w), .duty_i(eff_w[c]),
      .match_o(match_w[c]), .pwm_o(pwm_o[c])
    );
  end

endmodule

// File: rtl/qpwm_checker.sv
module qpwm_checker #(
  parameter int NCH = 3,
  parameter int TW  = 12,
  parameter int DW  = TW + 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [TW-1:0]          period,
  input logic [1:0]             phase,
  input logic [TW-1:0]          timer,
  input logic                   period_start,
  input logic [NCH-1:0][DW-1:0] pend_d,
  input logic [NCH-1:0][DW-1:0] work_d,
  input logic [NCH-1:0]         match,
  input logic [NCH-1:0]         pwm
);

  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  p_phase_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> phase == $past(phase) + 2'd1);

  p_timer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(phase) != 2'd3) |-> $stable(timer));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(period_start)) |-> work_d[i] == $past(pend_d[i]));

    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && !$past(period_start)) |-> $stable(work_d[i]));

    p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $rose(pwm[i])) |-> $past(period_start));

    p_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $fell(pwm[i])) |-> $past(match[i]));

    p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (period_start && pend_d[i] == '0) |=> !pwm[i]);

    p_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (period_start && pend_d[i][DW-1:2] > period) |=> pwm[i]);
  end

endmodule

bind qpwm_top qpwm_checker #(.NCH(NCH), .TW(TW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .period(period_i), .phase(phase_w), .timer(timer_w),
  .period_start(period_start_w), .pend_d(pend_w), .work_d(work_w),
  .match(match_w), .pwm(pwm_o)
);

// File: tb/tb_qpwm_top.sv
`timescale 1ns/1ps
module tb_qpwm_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] period_i = '0;
  logic [1:0]  prescale_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic        wr_hi_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic [1:0]  rd_sel_i = '0;
  logic        rd_hi_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic [2:0]  pwm_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  qpwm_top dut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .prescale_i(prescale_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_hi_i(wr_hi_i), .wr_data_i(wr_data_i),
    .rd_sel_i(rd_sel_i), .rd_hi_i(rd_hi_i), .rd_data_o(rd_data_o), .pwm_o(pwm_o)
  );

  // instruction cycles per timer count
  function automatic int div_of(input int ps);
    return 1 << (2 * ps);
  endfunction

  // clocks per period (R5)
  function automatic int per_len(input int p, input int ps);
    return (p + 1) * 4 * div_of(ps);
  endfunction

  // high clocks per period (R3, R4, R8, R9)
  function automatic int high_len(input int d, input int p, input int ps);
    int h;
    if (ps == 0) h = d;
    else         h = (d / 4) * 4 * div_of(ps);
    if (h > per_len(p, ps)) h = per_len(p, ps);
    return h;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int p, input int ps, input int d0, input int d1,
                          input int d2, input int nwin, input bit rnd);
    int T;
    int init_d [3];
    int shadow [3];
    int work_m [3];
    int hcnt [3];
    bit bad [3];
    int wch, wdu;
    bit wdo;
    T = per_len(p, ps);
    init_d[0] = d0; init_d[1] = d1; init_d[2] = d2;
    rst_n = 1'b0; wr_en_i = 1'b0;
    period_i = 12'(p); prescale_i = 2'(ps);
    repeat (3) @(negedge clk);
    rd_sel_i = 2'(p % 3); rd_hi_i = 1'b0;
    #1;
    check(pwm_o == 3'b000, "R2 pwm in reset", int'(pwm_o), 0);
    check(rd_data_o == 8'h00, "R2 pending low byte in reset", int'(rd_data_o), 0);
    rd_hi_i = 1'b1;
    #1;
    check(rd_data_o == 8'h00, "R2 pending high byte in reset", int'(rd_data_o), 0);
    for (int c = 0; c < 3; c++) shadow[c] = 0;
    wdo = 0; wch = 0; wdu = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int j = 1; j <= nwin * T; j++) begin
      int idx, n, w;
      @(negedge clk);
      idx = j - 1; n = idx % T; w = idx / T;
      if (n == 0) begin
        for (int c = 0; c < 3; c++) begin
          work_m[c] = shadow[c]; hcnt[c] = 0; bad[c] = 0;
        end
      end
      wr_en_i = 1'b0;
      for (int c = 0; c < 3; c++) begin
        bit e;
        e = (n < high_len(work_m[c], p, ps));
        if (pwm_o[c]) hcnt[c]++;
        if (pwm_o[c] != e) bad[c] = 1;
      end
      // byte writes into the pending copies (R1, R7)
      if (w == 0 && n >= 1 && n <= 6) begin
        int c;
        c = (n - 1) / 2;
        wr_en_i = 1'b1; wr_sel_i = 2'(c);
        if (n % 2 == 1) begin
          wr_hi_i = 1'b0; wr_data_i = 8'(init_d[c]);
          shadow[c] = (shadow[c] & 16'h3F00) | (init_d[c] & 8'hFF);
        end else begin
          wr_hi_i = 1'b1;
          wr_data_i = {2'($urandom), 6'(init_d[c] >> 8)};
          shadow[c] = (shadow[c] & 8'hFF) | (init_d[c] & 16'h3F00);
        end
      end else if (w > 0 && rnd && n == T / 2) begin
        wdo = $urandom_range(0, 1) == 1;
        if (wdo) begin
          wch = $urandom_range(0, 2);
          if ($urandom_range(0, 7) == 0) wdu = $urandom_range(0, 16383);
          else                           wdu = $urandom_range(0, (p + 2) * 4);
          wr_en_i = 1'b1; wr_sel_i = 2'(wch); wr_hi_i = 1'b0; wr_data_i = 8'(wdu);
          shadow[wch] = (shadow[wch] & 16'h3F00) | (wdu & 8'hFF);
        end
      end else if (w > 0 && rnd && wdo && n == T / 2 + 1) begin
        wr_en_i = 1'b1; wr_sel_i = 2'(wch); wr_hi_i = 1'b1;
        wr_data_i = {2'($urandom), 6'(wdu >> 8)};
        shadow[wch] = (shadow[wch] & 8'hFF) | (wdu & 16'h3F00);
      end
      if (n == T - 1) begin
        int rc;
        rc = w % 3;
        rd_sel_i = 2'(rc); rd_hi_i = w[0];
        #1;
        if (w[0]) check(int'(rd_data_o) == (shadow[rc] >> 8), "R1 high byte readback",
                        int'(rd_data_o), shadow[rc] >> 8);
        else      check(int'(rd_data_o) == (shadow[rc] & 8'hFF), "R1 low byte readback",
                        int'(rd_data_o), shadow[rc] & 8'hFF);
        for (int c = 0; c < 3; c++) begin
          int h;
          string tag;
          h = high_len(work_m[c], p, ps);
          if (work_m[c] == 0)       tag = "R8";
          else if (h == T)          tag = "R9";
          else if (ps == 0)         tag = "R3";
          else                      tag = "R4";
          check(!bad[c] && hcnt[c] == h,
                $sformatf("%s R5 R6 R7 ch%0d duty=%0d period=%0d ps=%0d", tag, c,
                          work_m[c], p, ps), hcnt[c], h);
        end
      end
    end
    wr_en_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2718));
    // directed corner cases
    run_case(3, 0, 0, 5, 15, 4, 1);          // zero, phase Q2, end on Q4 of last count
    run_case(2, 0, 12, 1, 16'h3FFF, 4, 1);   // above period, one quarter, maximum
    run_case(4, 1, 7, 2, 19, 3, 1);          // phase bits ignored at 1:4
    run_case(1, 3, 5, 8, 3, 3, 0);           // 1:64, clipped and zero
    run_case(5, 2, 9, 22, 13, 3, 1);         // 1:16
    // constrained random cases
    for (int k = 0; k < 8; k++) begin
      int p, ps;
      p  = $urandom_range(1, 6);
      ps = $urandom_range(0, 1);
      run_case(p, ps, $urandom_range(0, (p + 2) * 4), $urandom_range(0, (p + 2) * 4),
               $urandom_range(0, 16383), 5, 1);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule